// File: doc/BRIEF.md
# Duty-Cycle-Aware Performance Counter Pair

This block keeps two free-running counters that software reads to estimate the effective frequency of a core while a hardware controller duty-cycles it. The reference counter advances once per reference tick for as long as the operating system considers the core active. It keeps advancing while the duty-cycling controller holds the core in a forced idle state. The actual counter advances once per core clock-enable strobe, and only while the core is really executing. During forced idle it holds its value.

Software takes the growth of the actual counter between two reads and divides it by the growth of the reference counter over the same reads. It multiplies that quotient by the timestamp frequency. The result is the average effective frequency over the window the operating system sees as active, which runs from a wait-instruction exit to the next wait-instruction entry. As an example, a 1600 MHz core that is forced idle 75% of the time gives a ratio of 1/4, which is an effective 400 MHz. When the operating system has itself requested idle, neither counter moves.

Both counters wrap silently on overflow, and software can preset either one through a write port. A read strobe copies both counters in the same cycle into a pair of held output registers, so the two values software reads always belong together.

Top module: `perf_pair_ctr`

## Requirements
- R1: While `os_active` is 1, each cycle with `ref_tick` at 1 adds one to the reference counter, whatever the value of `forced_idle`.
- R2: While `os_active` is 1 and `forced_idle` is 0, each cycle with `core_clk_en` at 1 adds one to the actual counter. While `forced_idle` is 1, the actual counter holds its value.
- R3: With every cycle carrying both a reference tick and a core strobe, and the core forced idle for three cycles of every four, the actual-counter delta is exactly one quarter of the reference-counter delta.
- R4: While `os_active` is 0, neither counter changes, whatever the other inputs do.
- R5: A cycle with `wr_en` at 1 loads `wr_data` into the counter that `wr_sel` selects (0 selects the reference counter, 1 selects the actual counter). The value is visible from the next cycle. If an increment of that counter falls in the same cycle, the write wins.
- R6: A counter holding all ones that takes an increment becomes zero.
- R7: A cycle with `rd_en` at 1 copies both counters, as they stood before that cycle's update, into `rd_ref` and `rd_act`. The copies appear after the clock edge and hold until the next read.
- R8: Reset clears both counters and both read registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_clk_en | input | 1 | One pulse per executed core clock |
| ref_tick | input | 1 | One pulse per reference period |
| forced_idle | input | 1 | Core held idle by the duty-cycling controller |
| os_active | input | 1 | Core is in the OS-visible active state |
| wr_en | input | 1 | Preset strobe |
| wr_sel | input | 1 | Preset target: 0 reference, 1 actual |
| wr_data | input | CNT_W | Preset value |
| rd_en | input | 1 | Snapshot strobe |
| rd_ref | output | CNT_W | Captured reference count |
| rd_act | output | CNT_W | Captured actual count |

## Verification
The counters are driven under several patterns. Reference ticks alone move only the reference counter. Core strobes alone move only the actual counter. A run with forced idle asserted shows the two counters parting ways. A 25% duty pattern must give exactly a 1:4 ratio, and a run with the OS-requested idle state must leave both counters frozen. Presets that collide with increments show which of the two takes priority. A preset to all ones shows the wrap to zero. A snapshot taken in the middle of a running count, with both counters advancing every cycle, shows whether the two captured values come from the same cycle.

// File: rtl/perf_pair_pkg.sv
package perf_pair_pkg;
  localparam int unsigned LANES    = 2;
  localparam int unsigned LANE_REF = 0;
  localparam int unsigned LANE_ACT = 1;

  typedef enum logic {
    SEL_REF = 1'b0,
    SEL_ACT = 1'b1
  } lane_sel_e;
endpackage

// File: rtl/perf_inc_qual.sv
module perf_inc_qual
  import perf_pair_pkg::*;
(
  input  logic             core_clk_en,
  input  logic             ref_tick,
  input  logic             forced_idle,
  input  logic             os_active,
  output logic [LANES-1:0] inc
);
  always_comb begin
    inc           = '0;
    inc[LANE_REF] = os_active & ref_tick;
    inc[LANE_ACT] = os_active & core_clk_en & ~forced_idle;
  end
endmodule

// File: rtl/perf_ctr_lane.sv
module perf_ctr_lane #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] q
);
  logic [CNT_W-1:0] q_nxt;
  logic             q_en;

  always_comb begin
    q_en  = ld | inc;
    q_nxt = q;
    if (ld)       q_nxt = ld_val;
    else if (inc) q_nxt = q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/perf_snap.sv
module perf_snap
  import perf_pair_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cap,
  input  logic [LANES-1:0][CNT_W-1:0] live,
  output logic [LANES-1:0][CNT_W-1:0] held
);
  logic [LANES-1:0][CNT_W-1:0] held_nxt;

  always_comb begin
    held_nxt = held;
    if (cap) held_nxt = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held <= '0;
    else if (cap) held <= held_nxt;
  end
endmodule

// File: rtl/perf_pair_ctr.sv
module perf_pair_ctr
  import perf_pair_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_clk_en,
  input  logic             ref_tick,
  input  logic             forced_idle,
  input  logic             os_active,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [CNT_W-1:0] rd_ref,
  output logic [CNT_W-1:0] rd_act
);
  logic [LANES-1:0]            inc;
  logic [LANES-1:0]            ld;
  logic [LANES-1:0][CNT_W-1:0] cnt;
  logic [LANES-1:0][CNT_W-1:0] snap;
  logic [CNT_W-1:0]            cnt_ref;
  logic [CNT_W-1:0]            cnt_act;

  perf_inc_qual u_qual (
    .core_clk_en (core_clk_en),
    .ref_tick    (ref_tick),
    .forced_idle (forced_idle),
    .os_active   (os_active),
    .inc         (inc)
  );

  always_comb begin
    ld           = '0;
    ld[LANE_REF] = wr_en & (lane_sel_e'(wr_sel) == SEL_REF);
    ld[LANE_ACT] = wr_en & (lane_sel_e'(wr_sel) == SEL_ACT);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    perf_ctr_lane #(.CNT_W(CNT_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (inc[g]),
      .ld     (ld[g]),
      .ld_val (wr_data),
      .q      (cnt[g])
    );
  end

  perf_snap #(.CNT_W(CNT_W)) u_snap (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (rd_en),
    .live  (cnt),
    .held  (snap)
  );

  assign cnt_ref = cnt[LANE_REF];
  assign cnt_act = cnt[LANE_ACT];
  assign rd_ref  = snap[LANE_REF];
  assign rd_act  = snap[LANE_ACT];
endmodule

// File: rtl/perf_pair_chk.sv
module perf_pair_chk #(
  parameter int unsigned CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_clk_en,
  input logic             ref_tick,
  input logic             forced_idle,
  input logic             os_active,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             rd_en,
  input logic [CNT_W-1:0] cnt_ref,
  input logic [CNT_W-1:0] cnt_act,
  input logic [CNT_W-1:0] rd_ref,
  input logic [CNT_W-1:0] rd_act
);
  logic wr_ref_hit;
  logic wr_act_hit;
  assign wr_ref_hit = wr_en & ~wr_sel;
  assign wr_act_hit = wr_en & wr_sel;

  a_r1_ref_through_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (os_active && ref_tick && forced_idle && !wr_ref_hit)
      |=> cnt_ref == $past(cnt_ref) + CNT_W'(1));

  a_r2_act_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (forced_idle && !wr_act_hit) |=> $stable(cnt_act));

  a_r2_act_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (os_active && core_clk_en && !forced_idle && !wr_act_hit)
      |=> cnt_act == $past(cnt_act) + CNT_W'(1));

  a_r4_os_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!os_active && !wr_en) |=> ($stable(cnt_ref) && $stable(cnt_act)));

  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_sel ? cnt_act : cnt_ref) == $past(wr_data));

  a_r7_coherent_snap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_ref == $past(cnt_ref) && rd_act == $past(cnt_act)));

  a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ($stable(rd_ref) && $stable(rd_act)));
endmodule

bind perf_pair_ctr perf_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_clk_en (core_clk_en),
  .ref_tick    (ref_tick),
  .forced_idle (forced_idle),
  .os_active   (os_active),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .rd_en       (rd_en),
  .cnt_ref     (cnt_ref),
  .cnt_act     (cnt_act),
  .rd_ref      (rd_ref),
  .rd_act      (rd_act)
);

// File: tb/perf_pair_ctr_bench.sv
`timescale 1ns/1ps
module perf_pair_ctr_bench;
  localparam int unsigned W = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         core_clk_en, ref_tick, forced_idle, os_active;
  logic         wr_en, wr_sel, rd_en;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_ref, rd_act;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  perf_pair_ctr #(.CNT_W(W)) u_perf_pair_ctr (
    .clk (clk), .rst_n (rst_n), .core_clk_en (core_clk_en), .ref_tick (ref_tick),
    .forced_idle (forced_idle), .os_active (os_active), .wr_en (wr_en),
    .wr_sel (wr_sel), .wr_data (wr_data), .rd_en (rd_en),
    .rd_ref (rd_ref), .rd_act (rd_act)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    core_clk_en = 0; ref_tick = 0; forced_idle = 0; os_active = 0;
    wr_en = 0; wr_sel = 0; wr_data = '0; rd_en = 0;
  endtask

  task automatic preset(input logic sel, input logic [W-1:0] val);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = val;
    @(posedge clk);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clear_both();
    preset(1'b0, '0);
    preset(1'b1, '0);
  endtask

  task automatic run(input int n, input logic ce, input logic tk, input logic fi, input logic oa);
    @(negedge clk);
    core_clk_en = ce; ref_tick = tk; forced_idle = fi; os_active = oa;
    repeat (n) @(posedge clk);
    @(negedge clk);
    core_clk_en = 0; ref_tick = 0; forced_idle = 0; os_active = 0;
  endtask

  task automatic read_pair(output logic [W-1:0] r, output logic [W-1:0] a);
    @(negedge clk); rd_en = 1;
    @(posedge clk);
    @(negedge clk); rd_en = 0;
    r = rd_ref; a = rd_act;
  endtask

  task automatic t_reset();
    logic [W-1:0] r, a;
    #1; check("R8 ref after reset", rd_ref, '0);
    check("R8 act after reset", rd_act, '0);
    read_pair(r, a);
    check("R8 ref counter after reset", r, '0);
    check("R8 act counter after reset", a, '0);
  endtask

  task automatic t_separate();
    logic [W-1:0] r, a;
    clear_both();
    run(9, 1'b0, 1'b1, 1'b0, 1'b1);
    read_pair(r, a);
    check("R1 ref ticks only", r, 64'd9);
    check("R2 act untouched by ref ticks", a, 64'd0);
    run(6, 1'b1, 1'b0, 1'b0, 1'b1);
    read_pair(r, a);
    check("R1 ref untouched by core strobes", r, 64'd9);
    check("R2 core strobes only", a, 64'd6);
  endtask

  task automatic t_forced_idle();
    logic [W-1:0] r, a;
    clear_both();
    run(11, 1'b1, 1'b1, 1'b1, 1'b1);
    read_pair(r, a);
    check("R1 ref runs in forced idle", r, 64'd11);
    check("R2 act frozen in forced idle", a, 64'd0);
  endtask

  task automatic t_duty_quarter();
    logic [W-1:0] r, a;
    clear_both();
    for (int i = 0; i < 100; i++) begin
      run(1, 1'b1, 1'b1, 1'b0, 1'b1);
      run(3, 1'b1, 1'b1, 1'b1, 1'b1);
    end
    read_pair(r, a);
    check("R3 ref delta at 25% duty", r, 64'd400);
    check("R3 act delta at 25% duty", a, 64'd100);
    check("R3 ratio act*4 equals ref", a * 4, r);
  endtask

  task automatic t_os_idle();
    logic [W-1:0] r, a;
    preset(1'b0, 64'd50);
    preset(1'b1, 64'd70);
    run(8, 1'b1, 1'b1, 1'b0, 1'b0);
    run(5, 1'b1, 1'b1, 1'b1, 1'b0);
    read_pair(r, a);
    check("R4 ref frozen in OS idle", r, 64'd50);
    check("R4 act frozen in OS idle", a, 64'd70);
  endtask

  task automatic t_write_wins();
    logic [W-1:0] r, a;
    clear_both();
    @(negedge clk);
    core_clk_en = 1; ref_tick = 1; os_active = 1;
    wr_en = 1; wr_sel = 1; wr_data = 64'd5;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; core_clk_en = 0; ref_tick = 0; os_active = 0;
    read_pair(r, a);
    check("R5 act write beats increment", a, 64'd5);
    check("R1 ref still counted beside act write", r, 64'd1);
    @(negedge clk);
    core_clk_en = 1; ref_tick = 1; os_active = 1;
    wr_en = 1; wr_sel = 0; wr_data = 64'h1234_5678_9abc_def0;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; core_clk_en = 0; ref_tick = 0; os_active = 0;
    read_pair(r, a);
    check("R5 ref write beats increment", r, 64'h1234_5678_9abc_def0);
    check("R2 act still counted beside ref write", a, 64'd6);
  endtask

  task automatic t_wrap();
    logic [W-1:0] r, a;
    preset(1'b0, '1);
    preset(1'b1, '1);
    run(1, 1'b1, 1'b1, 1'b0, 1'b1);
    read_pair(r, a);
    check("R6 ref wraps to zero", r, '0);
    check("R6 act wraps to zero", a, '0);
    run(2, 1'b1, 1'b1, 1'b0, 1'b1);
    read_pair(r, a);
    check("R6 ref counts on after wrap", r, 64'd2);
  endtask

  task automatic t_coherent();
    logic [W-1:0] r, a;
    clear_both();
    @(negedge clk);
    core_clk_en = 1; ref_tick = 1; os_active = 1;
    repeat (7) @(posedge clk);
    @(negedge clk); rd_en = 1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 0; core_clk_en = 0; ref_tick = 0; os_active = 0;
    check("R7 ref snapshot before update", rd_ref, 64'd7);
    check("R7 act snapshot same cycle", rd_act, 64'd7);
    run(4, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R7 ref snapshot held without read", rd_ref, 64'd7);
    read_pair(r, a);
    check("R7 ref live after capture", r, 64'd12);
    check("R7 act live after capture", a, 64'd12);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_separate();
    t_forced_idle();
    t_duty_quarter();
    t_os_idle();
    t_write_wins();
    t_wrap();
    t_coherent();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule